// File: doc/BRIEF.md
# Byte-Addressed SPI Register Slave

This block is a serial slave that gives an external controller access to a bank of 16-bit registers over a four-wire SPI link in mode 3: the clock idles high, the slave changes its output on falling edges and samples input on rising edges. Each chip-select frame is 16 bits long, sent most significant bit first, and carries exactly one command. A command is a read request, a write of one byte, or a burst trigger. The link is full duplex. The answer to a read appears on the output line during the frame that follows the request, so the controller can send the next request while it receives the previous answer.

Every register has two byte addresses. The even address names the low byte and the odd address names the high byte. Read-only sample registers hold 14 bits of data, a new-data flag and a live error flag, and they are reloaded together by a sample strobe. Writable configuration bytes are driven out to the rest of the chip. One reserved read address starts a burst. The burst returns every sample register in ascending address order, one per frame, for as long as chip select stays low.

The SPI clock, the chip select and the input data are synchronised into a faster system clock, and all edges are detected there.

Top module: `spi_byte_regs`

## Requirements
- R1: The bit on `miso` changes only after a detected falling edge of `sclk`. The first falling edge of a frame presents the most significant bit of the response. Each later falling edge advances to the next bit, so the controller can sample on rising edges, MSB first.
- R2: On the 16th rising edge the received word is decoded as follows: bit 15 is the direction (1 = write), bits 14:8 are a 7-bit byte address, and bits 7:0 are the write data.
- R3: A read request at byte address A is answered in the next frame with the 16-bit word at word index A[6:1]. Addresses that map to no register answer 0x0000.
- R4: A write stores its data byte at the end of the frame into the configuration word at index A[6:1]. An even A writes bits 7:0 and an odd A writes bits 15:8. Configuration words occupy word indices 13 to 20, which are byte addresses 0x1A to 0x29. Writes to any other address change nothing.
- R5: The frame that follows a write frame returns 0x0000.
- R6: A read request at byte address 0x3E starts a burst. The following frames return the sample registers at byte addresses 0x02 to 0x16 (word indices 1 to 11) in ascending order, one per frame, while chip select stays low. Commands received in burst frames are ignored. The frame after the last burst word returns 0x0000.
- R7: A sample register word is laid out as follows: bit 15 is the new-data flag, bit 14 is the value of `status_any` at the moment the word begins to shift out, and bits 13:0 are the data.
- R8: A `smp_valid` pulse loads all sample registers from `smp_data` (register at word index k+1 takes bits [14k+13:14k]) and sets every new-data flag. A flag clears when its word begins to shift out. When both happen in the same cycle, setting the flag wins.
- R9: Raising chip select in the middle of a frame discards that frame, so a partial write stores nothing. Raising chip select at any point also ends a burst, and the next frame returns 0x0000.
- R10: After reset the configuration words are 0, all new-data flags are 0, `miso` is 0 and no response is pending, so the first frame returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI clock, idle high |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller (registered) |
| smp_valid | input | 1 | Strobe that loads all sample registers |
| smp_data | input | 154 | Packed 14-bit sample values, one per sample register |
| status_any | input | 1 | Summary error flag reported in bit 14 of sample words |
| cfg_words | output | 128 | Packed configuration words, index 13 in bits 15:0 |

## Verification
The hardest situation to reach is the interaction between chip select and a response that is already pending: a burst cut off partway, or a write cut off before its 16th edge. These cases decide whether new-data flags are consumed and whether bytes are stored. The bench reaches them by raising chip select after a chosen number of burst frames, and again after seven bits of a write. It then re-reads the affected registers so that the flags and the configuration bytes are observed at the ports. Full bursts are run with chip select held low across twelve frames, and each burst frame carries a write command that must be ignored.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = WORD_W - 2;
  localparam int ADDR_W = 7;
  localparam int IDX_W  = ADDR_W - 1;

  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_REG   = 2'd1,
    PEND_BURST = 2'd2
  } pend_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_rise,
  output logic cs_active,
  output logic mosi_bit
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] s_sclk, s_cs, s_mosi;
  logic sclk_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sclk <= '1;
      s_cs   <= '1;
      s_mosi <= '0;
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      s_sclk <= {s_sclk[STAGES-2:0], sclk};
      s_cs   <= {s_cs[STAGES-2:0], cs_n};
      s_mosi <= {s_mosi[STAGES-2:0], mosi};
      sclk_d <= s_sclk[TOP];
      cs_d   <= s_cs[TOP];
    end
  end

  assign sclk_rise = s_sclk[TOP] & ~sclk_d;
  assign sclk_fall = ~s_sclk[TOP] & sclk_d;
  assign cs_rise   = s_cs[TOP] & ~cs_d;
  assign cs_active = ~s_cs[TOP];
  assign mosi_bit  = s_mosi[TOP];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_rf_pkg::*;
#(
  parameter int FRAME_W = WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               cs_rise,
  input  logic               cs_active,
  input  logic               mosi_bit,
  input  logic [FRAME_W-1:0] load_word,
  output logic               load_req,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_cmd,
  output logic [$clog2(FRAME_W)-1:0] bit_cnt,
  output logic               miso
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] rx_q, tx_q;

  // First falling edge of a frame fetches the response word.
  assign load_req = cs_active && sclk_fall && (bit_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      frame_cmd  <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (cs_rise) begin
        bit_cnt <= '0;
      end else if (cs_active) begin
        if (sclk_fall) begin
          if (bit_cnt == '0) tx_q <= load_word;
          else               tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
        if (sclk_rise) begin
          rx_q <= {rx_q[FRAME_W-2:0], mosi_bit};
          if (bit_cnt == LAST_BIT) begin
            frame_cmd  <= {rx_q[FRAME_W-2:0], mosi_bit};
            frame_done <= 1'b1;
            bit_cnt    <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign miso = tx_q[FRAME_W-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_rf_pkg::*;
#(
  parameter int NUM_OUT  = 11,
  parameter int OUT_BASE = 1,
  parameter int NUM_CFG  = 8,
  parameter int CFG_BASE = 13
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        smp_valid,
  input  logic [NUM_OUT*DATA_W-1:0]   smp_data,
  input  logic                        status_any,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        rd_take,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [7:0]                  wr_byte,
  output logic [WORD_W-1:0]           rd_word,
  output logic [NUM_CFG*WORD_W-1:0]   cfg_words,
  output logic [NUM_OUT-1:0]          nd_vec
);
  logic [DATA_W-1:0] out_data [NUM_OUT];
  logic [7:0]        cfg_lo   [NUM_CFG];
  logic [7:0]        cfg_hi   [NUM_CFG];
  logic [IDX_W-1:0]  wr_idx;

  assign wr_idx = wr_addr[ADDR_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      nd_vec <= '0;
      for (int i = 0; i < NUM_OUT; i++) out_data[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (smp_valid) begin
          out_data[i] <= smp_data[i*DATA_W +: DATA_W];
          nd_vec[i]   <= 1'b1;
        end else if (rd_take && rd_idx == IDX_W'(OUT_BASE + i)) begin
          nd_vec[i]   <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CFG; c++) begin
        cfg_lo[c] <= '0;
        cfg_hi[c] <= '0;
      end
    end else if (wr_en) begin
      for (int c = 0; c < NUM_CFG; c++) begin
        if (wr_idx == IDX_W'(CFG_BASE + c)) begin
          if (wr_addr[0]) cfg_hi[c] <= wr_byte;
          else            cfg_lo[c] <= wr_byte;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      assign cfg_words[g*WORD_W +: WORD_W] = {cfg_hi[g], cfg_lo[g]};
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_OUT; i++)
      if (rd_idx == IDX_W'(OUT_BASE + i)) rd_word = {nd_vec[i], status_any, out_data[i]};
    for (int c = 0; c < NUM_CFG; c++)
      if (rd_idx == IDX_W'(CFG_BASE + c)) rd_word = {cfg_hi[c], cfg_lo[c]};
  end
endmodule

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
  import spi_rf_pkg::*;
#(
  parameter int NUM_OUT     = 11,
  parameter int NUM_CFG     = 8,
  parameter int CFG_BASE    = 13,
  parameter int BURST_ADDR  = 'h3E,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sclk,
  input  logic                        cs_n,
  input  logic                        mosi,
  output logic                        miso,
  input  logic                        smp_valid,
  input  logic [NUM_OUT*DATA_W-1:0]   smp_data,
  input  logic                        status_any,
  output logic [NUM_CFG*WORD_W-1:0]   cfg_words
);
  localparam int OUT_BASE = 1;
  localparam logic [IDX_W-1:0]  FIRST_IDX = IDX_W'(OUT_BASE);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(OUT_BASE + NUM_OUT - 1);
  localparam logic [ADDR_W-1:0] BURST_A   = ADDR_W'(BURST_ADDR);

  logic sclk_rise, sclk_fall, cs_rise, cs_active, mosi_bit;
  logic load_req, frame_done;
  logic [WORD_W-1:0] frame_cmd, rd_word, load_word;
  logic [$clog2(WORD_W)-1:0] bit_cnt;
  logic [NUM_OUT-1:0] nd_vec;

  pend_e            pend_kind;
  logic [IDX_W-1:0] pend_idx;
  logic             cur_burst;
  logic             rd_take, wr_en;
  logic [ADDR_W-1:0] cmd_addr;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
    .cs_active(cs_active), .mosi_bit(mosi_bit)
  );

  spi_frame_engine #(.FRAME_W(WORD_W)) u_frame (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .cs_active(cs_active), .mosi_bit(mosi_bit),
    .load_word(load_word), .load_req(load_req), .frame_done(frame_done),
    .frame_cmd(frame_cmd), .bit_cnt(bit_cnt), .miso(miso)
  );

  assign cmd_addr  = frame_cmd[WORD_W-2 -: ADDR_W];
  assign rd_take   = load_req && (pend_kind != PEND_NONE);
  assign load_word = (pend_kind == PEND_NONE) ? '0 : rd_word;
  assign wr_en     = frame_done && !cur_burst && frame_cmd[WORD_W-1];

  spi_reg_bank #(
    .NUM_OUT(NUM_OUT), .OUT_BASE(OUT_BASE), .NUM_CFG(NUM_CFG), .CFG_BASE(CFG_BASE)
  ) u_bank (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .status_any(status_any), .rd_idx(pend_idx), .rd_take(rd_take),
    .wr_en(wr_en), .wr_addr(cmd_addr), .wr_byte(frame_cmd[7:0]),
    .rd_word(rd_word), .cfg_words(cfg_words), .nd_vec(nd_vec)
  );

  // Pending response: what the next frame's first falling edge sends.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_kind <= PEND_NONE;
      pend_idx  <= '0;
      cur_burst <= 1'b0;
    end else if (cs_rise) begin
      cur_burst <= 1'b0;
      if (pend_kind == PEND_BURST) pend_kind <= PEND_NONE;
    end else if (load_req) begin
      case (pend_kind)
        PEND_REG: begin
          pend_kind <= PEND_NONE;
          cur_burst <= 1'b0;
        end
        PEND_BURST: begin
          cur_burst <= 1'b1;
          if (pend_idx == LAST_IDX) pend_kind <= PEND_NONE;
          else                      pend_idx  <= pend_idx + 1'b1;
        end
        default: cur_burst <= 1'b0;
      endcase
    end else if (frame_done && !cur_burst) begin
      if (frame_cmd[WORD_W-1]) begin
        pend_kind <= PEND_NONE;
      end else if (cmd_addr == BURST_A) begin
        pend_kind <= PEND_BURST;
        pend_idx  <= FIRST_IDX;
      end else begin
        pend_kind <= PEND_REG;
        pend_idx  <= cmd_addr[ADDR_W-1:1];
      end
    end
  end
endmodule

// File: rtl/spi_byte_regs_chk.sv
module spi_byte_regs_chk
  import spi_rf_pkg::*;
#(
  parameter int NUM_OUT = 11,
  parameter int NUM_CFG = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      miso,
  input logic                      sclk_fall,
  input logic                      frame_done,
  input logic                      cs_rise,
  input logic                      smp_valid,
  input logic [3:0]                bit_cnt,
  input logic [NUM_OUT-1:0]        nd_vec,
  input logic [NUM_CFG*WORD_W-1:0] cfg_words,
  input pend_e                     pend_kind
);
  // R1
  miso_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> $past(sclk_fall));

  // R4
  cfg_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_words) |-> $past(frame_done));

  // R8
  nd_set_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (nd_vec == '1));

  // R9
  cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (bit_cnt == '0 && pend_kind != PEND_BURST));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (nd_vec == '0 && cfg_words == '0 && pend_kind == PEND_NONE));
endmodule

bind spi_byte_regs spi_byte_regs_chk #(.NUM_OUT(NUM_OUT), .NUM_CFG(NUM_CFG)) u_chk (
  .clk(clk), .rst(rst), .miso(miso), .sclk_fall(sclk_fall),
  .frame_done(frame_done), .cs_rise(cs_rise), .smp_valid(smp_valid),
  .bit_cnt(bit_cnt), .nd_vec(nd_vec), .cfg_words(cfg_words), .pend_kind(pend_kind)
);

// File: tb/spi_byte_regs_tb.sv
module spi_byte_regs_tb;
  localparam int NO = 11, NC = 8, CB = 13, DW = 14, HP = 8;

  logic clk = 0, rst = 1, sclk = 1, cs_n = 1, mosi = 0;
  logic smp_valid = 0, status_any = 0;
  logic [NO*DW-1:0] smp_data = '0;
  logic miso;
  logic [NC*16-1:0] cfg_words;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_byte_regs u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .smp_valid(smp_valid), .smp_data(smp_data), .status_any(status_any),
    .cfg_words(cfg_words)
  );

  // Behavioural reference model
  logic [DW-1:0] m_data [32];
  bit            m_nd   [32];
  logic [7:0]    m_lo   [32];
  logic [7:0]    m_hi   [32];
  int            m_kind = 0;   // 0 none, 1 register, 2 burst
  int            m_idx  = 0;
  bit            m_cur  = 0;

  function automatic logic [15:0] m_read(int idx);
    if (idx >= 1 && idx <= NO) return {m_nd[idx], status_any, m_data[idx]};
    if (idx >= CB && idx < CB + NC) return {m_hi[idx], m_lo[idx]};
    return 16'h0000;
  endfunction

  function automatic logic [15:0] m_load();
    logic [15:0] w = 16'h0000;
    if (m_kind == 0) m_cur = 0;
    else begin
      w = m_read(m_idx);
      if (m_idx >= 1 && m_idx <= NO) m_nd[m_idx] = 0;
      if (m_kind == 1) begin m_kind = 0; m_cur = 0; end
      else begin
        m_cur = 1;
        if (m_idx == NO) m_kind = 0; else m_idx++;
      end
    end
    return w;
  endfunction

  function automatic void m_complete(logic [15:0] din);
    int a = int'(din[14:8]);
    if (m_cur) return;
    if (din[15]) begin
      m_kind = 0;
      if ((a >> 1) >= CB && (a >> 1) < CB + NC) begin
        if (a[0]) m_hi[a >> 1] = din[7:0]; else m_lo[a >> 1] = din[7:0];
      end
    end else if (a == 'h3E) begin m_kind = 2; m_idx = 1; end
    else begin m_kind = 1; m_idx = a >> 1; end
  endfunction

  function automatic void m_cs_high();
    if (m_kind == 2) m_kind = 0;
    m_cur = 0;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_cfg(string req);
    logic [NC*16-1:0] e;
    for (int c = 0; c < NC; c++) e[c*16 +: 16] = {m_hi[CB+c], m_lo[CB+c]};
    check(cfg_words == e, req, cfg_words, e);
  endtask

  // Shift nbits of din; returns bits sampled on miso before each rising edge.
  task automatic xfer(input logic [15:0] din, input int nbits, input bit keep_low,
                      output logic [15:0] dout);
    dout = '0;
    if (cs_n) begin
      @(negedge clk); cs_n = 0;
      repeat (4) @(negedge clk);
    end
    for (int b = 15; b > 15 - nbits; b--) begin
      sclk = 0; mosi = din[b];
      repeat (HP) @(negedge clk);
      dout[b] = miso;
      sclk = 1;
      repeat (HP) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    if (!keep_low) begin
      cs_n = 1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic frame(input logic [15:0] din, input bit keep_low, input string req);
    logic [15:0] exp, got;
    exp = m_load();
    xfer(din, 16, keep_low, got);
    check(got === exp, req, got, exp);
    m_complete(din);
    if (!keep_low) m_cs_high();
    check_cfg("R4 cfg");
  endtask

  task automatic load_samples(int seed);
    @(negedge clk);
    for (int i = 0; i < NO; i++) begin
      smp_data[i*DW +: DW] = DW'((i + 1) * 'h1235 + seed);
      m_data[i+1] = DW'((i + 1) * 'h1235 + seed);
      m_nd[i+1] = 1;
    end
    smp_valid = 1;
    @(negedge clk); smp_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] junk;
    for (int i = 0; i < 32; i++) begin m_data[i] = '0; m_nd[i] = 0; m_lo[i] = '0; m_hi[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(miso == 1'b0, "R10 miso", miso, 0);
    check_cfg("R10 cfg");

    // R4 byte writes, R5 zero after write, R3 read next frame
    frame(16'h9AA5, 0, "R10 first frame");
    frame(16'h9B3C, 0, "R5 after write");
    frame(16'h1A00, 0, "R5 after write");
    frame(16'hA177, 0, "R3 cfg word 0x1A");
    frame(16'h2100, 0, "R5 after write");
    frame(16'h1B00, 0, "R3 cfg 0x20");
    frame(16'h8A55, 0, "R3 odd addr");
    frame(16'h0A00, 0, "R5 after write");
    // R7 R8 sample format and new-data flag
    load_samples(7);
    frame(16'h0A00, 0, "R4 write to sample reg ignored");
    frame(16'h0A00, 0, "R8 nd set");
    frame(16'h0C00, 0, "R8 nd cleared");
    status_any = 1;
    frame(16'h5000, 0, "R7 status bit");
    frame(16'h7F00, 0, "R3 unmapped");
    status_any = 0;
    frame(16'h0000, 0, "R3 unmapped");

    // R6 full burst with chip select held low, commands ignored
    load_samples(99);
    frame(16'h0400, 0, "R3 pre burst");
    frame(16'h3E00, 1, "R7 pre burst");
    for (int k = 0; k < NO; k++) frame(16'h9AFF, 1, "R6 burst word");
    frame(16'h1A00, 0, "R6 after burst");
    frame(16'h0000, 0, "R6 cmd after burst");

    // R9 burst cut short by chip select
    load_samples(3);
    frame(16'h3E00, 1, "R9 pre burst");
    for (int k = 0; k < 3; k++) frame(16'h0000, 1, "R6 partial burst");
    frame(16'h0000, 0, "R6 partial burst last");
    frame(16'h0A00, 0, "R9 burst ended");
    frame(16'h0000, 0, "R9 nd kept after abort");

    // R9 partial write frame discarded
    frame(16'h1A00, 0, "R3 before abort");
    junk = m_load();
    xfer(16'h9C77, 7, 0, junk);
    m_cs_high();
    check_cfg("R9 partial write");
    frame(16'h1C00, 0, "R9 after partial");
    frame(16'h0000, 0, "R9 cfg 0x1C");

    // R2 R1 mixed high/low byte pattern
    frame(16'hA9C3, 0, "R2 write high byte");
    frame(16'h2800, 0, "R2 after write");
    frame(16'h0000, 0, "R1 R2 readback");
    // R8 flag set wins over clear
    load_samples(55);
    frame(16'h0200, 0, "R8 prep");
    frame(16'h0200, 0, "R8 nd first");
    frame(16'h0000, 0, "R8 nd cleared");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule